// File: doc/BRIEF.md
# Shared-Level Prioritised Interrupt Controller

This block collects level-sensitive interrupt requests from a system and presents each processor with a 4-bit priority code. The code is the highest level among the requests that are pending and unmasked, or 0 when none qualify. The requests come from four asynchronous error sources, nine onboard device lines, seven expansion-bus levels and seven backplane-bus levels. There is also one private timer line per processor, and a bank of fifteen software interrupts for each processor. Several sources share most of the levels. Software therefore reads a raw pending word to find out which of the sharers fired.

Global sources each have one bit in a 32-bit mask. Bit 31 is a master gate over all of them. The mask is never written directly. One address sets the bits that are 1 in the written word, and another address clears them. Device sources reach only the processor named by a target register. Error sources reach every processor. Each processor's software interrupts are raised and lowered through its own pair of addresses. The code for every processor comes from a single register that is loaded on each clock.

Top module: `irqc_top`

## Requirements
- R1: After reset all 32 mask bits are 1, every processor's level code is 0, the target register reads 0 and every software interrupt bank reads 0.
- R2: A write to word address 1 sets exactly the mask bits that are 1 in the data. A write to word address 2 clears exactly the mask bits that are 1 in the data. Zero data bits leave the mask unchanged. A read of address 1 or 2 returns the mask.
- R3: A read of word address 0 returns the raw request lines, ignoring the mask. The layout is: bits 30..27 = err_req[3:0], bits 22..14 = dev_req[8:0], bits 13..7 = xbus_req[6:0], bits 6..0 = bpl_req[6:0]. All other bits are 0.
- R4: Each source has a fixed level:
  - errors: 15
  - dev_req[8..0]: 11, 9, 8, 10, 4, 13, 6, 12, 12
  - expansion or backplane bus line k (index k-1): 2, 3, 5, 7, 9, 11, 13 for k = 1..7
  - a processor's timer line: 14
  - software bit n: level n
- R5: A processor's level code is the highest level among its qualifying requests, or 0 when none qualify. It appears on the clock edge after the request or mask state that causes it.
- R6: While mask bit 31 is 1, no global source (device or error) contributes to any level. Software interrupts and processor timers are not affected.
- R7: For processor c, a write to word address 16+4c sets that processor's software bits where data bits 15..1 are 1. A write to 17+4c clears them. Data bit 0 and bits 31..16 are ignored. A read of 16+4c returns the bank in bits 15..1. No other processor's bank changes.
- R8: A processor's timer line raises only that processor to level 14 and cannot be masked.
- R9: Device and bus sources reach only the processor whose number is held in the target register. The register is written and read at word address 3, in its low bits.
- R10: Unmasked error sources raise every processor to level 15, whatever the target register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| err_req | input | 4 | Asynchronous error requests |
| dev_req | input | 9 | Onboard device requests |
| xbus_req | input | 7 | Expansion-bus level requests |
| bpl_req | input | 7 | Backplane-bus level requests |
| tmr_req | input | NCPU (4) | Per-processor timer requests |
| cpu_level | output | 4*NCPU (16) | Level code of processor c in bits 4c+3..4c |

## Verification
Two functions can coincide in one cycle: a software interrupt raised on a processor and a device source steered to that same processor. The bench provokes this by setting a software bit above the device's level, then below it, then at the same level. In each case it judges the code against a model that takes the maximum over both kinds of request. A second coincidence arises when setting mask-all overlaps an active processor timer. The bench checks that the timer's level survives while the device's level vanishes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned NLVL     = 1 << LVL_W;
  localparam int unsigned MALL_BIT = 31;
  localparam int unsigned ERR_LO   = 27;
  localparam int unsigned ERR_HI   = 30;
  localparam int unsigned ERR_N    = ERR_HI - ERR_LO + 1;
  localparam int unsigned DEV_LO   = 14;
  localparam int unsigned DEV_N    = 9;
  localparam int unsigned BUS_N    = 7;
  localparam int unsigned XBUS_LO  = 7;
  localparam int unsigned BPL_LO   = 0;
  localparam int unsigned TMR_LVL  = 14;
  localparam int unsigned ERR_LVL  = 15;

  localparam int unsigned A_PEND     = 0;
  localparam int unsigned A_MSET     = 1;
  localparam int unsigned A_MCLR     = 2;
  localparam int unsigned A_TGT      = 3;
  localparam int unsigned A_CPU_BASE = 16;
  localparam int unsigned A_CPU_STEP = 4;

  // level of shared bus line k (1..7)
  function automatic logic [LVL_W-1:0] bus_level(input int unsigned k);
    if (k <= 2) return LVL_W'(k + 1);
    else        return LVL_W'(2 * k - 1);
  endfunction

  // level carried by bit b of the global source word, 0 if unused
  function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
    logic [LVL_W-1:0] r;
    r = '0;
    if (b >= ERR_LO && b <= ERR_HI) r = LVL_W'(ERR_LVL);
    else if (b >= XBUS_LO && b < XBUS_LO + BUS_N) r = bus_level(b - XBUS_LO + 1);
    else if (b < BPL_LO + BUS_N) r = bus_level(b - BPL_LO + 1);
    else begin
      case (b)
        22: r = 4'd11;
        21: r = 4'd9;
        20: r = 4'd8;
        19: r = 4'd10;
        18: r = 4'd4;
        17: r = 4'd13;
        16: r = 4'd6;
        15: r = 4'd12;
        14: r = 4'd12;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] mask_q
);

  logic [WORD_W-1:0] mask_d;
  logic              mask_ce;

  always_comb begin
    mask_ce = set_en | clr_en;
    mask_d  = mask_q;
    if (clr_en) mask_d = mask_d & ~wdata;
    if (set_en) mask_d = mask_d | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_ce) mask_q <= mask_d;
  end

  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_q)); // R2

endmodule

// File: rtl/irqc_src_map.sv
module irqc_src_map
  import irqc_pkg::*;
(
  input  logic [WORD_W-1:0] src_raw,
  input  logic [WORD_W-1:0] mask_q,
  output logic [NLVL-1:0]   dev_vec,
  output logic [NLVL-1:0]   err_vec
);

  logic [WORD_W-2:0] qual;

  genvar b;
  generate
    for (b = 0; b < WORD_W - 1; b++) begin : g_qual
      assign qual[b] = src_raw[b] & ~mask_q[b] & ~mask_q[MALL_BIT];
    end
  endgenerate

  always_comb begin
    dev_vec = '0;
    err_vec = '0;
    for (int i = 0; i < WORD_W - 1; i++) begin
      if (src_level(i) != '0) begin
        if (i >= ERR_LO && i <= ERR_HI)
          err_vec[src_level(i)] = err_vec[src_level(i)] | qual[i];
        else
          dev_vec[src_level(i)] = dev_vec[src_level(i)] | qual[i];
      end
    end
  end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
(
  input  logic [NLVL-1:0]  vec,
  output logic [LVL_W-1:0] code
);

  always_comb begin
    code = '0;
    for (int i = 1; i < NLVL; i++)
      if (vec[i]) code = LVL_W'(i);
  end

endmodule

// File: rtl/irqc_soft_bank.sv
module irqc_soft_bank
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [NLVL-1:0] wbits,
  output logic [NLVL-1:0] soft_q
);

  logic [NLVL-1:0] soft_d;
  logic [NLVL-1:0] usable;
  logic            soft_ce;

  assign usable = {wbits[NLVL-1:1], 1'b0};

  always_comb begin
    soft_ce = set_en | clr_en;
    soft_d  = soft_q;
    if (clr_en) soft_d = soft_d & ~usable;
    if (set_en) soft_d = soft_d | usable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       soft_q <= '0;
    else if (soft_ce) soft_q <= soft_d;
  end

  AST_SOFT_BIT0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q[0] == 1'b0); // R7
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(soft_q)); // R7

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic [ERR_N-1:0]      err_req,
  input  logic [DEV_N-1:0]      dev_req,
  input  logic [BUS_N-1:0]      xbus_req,
  input  logic [BUS_N-1:0]      bpl_req,
  input  logic [NCPU-1:0]       tmr_req,
  output logic [NCPU*LVL_W-1:0] cpu_level
);

  localparam int unsigned CPU_W   = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int unsigned GAP_W   = ERR_LO - (DEV_LO + DEV_N);

  logic [WORD_W-1:0] src_raw;
  logic [WORD_W-1:0] mask_q;
  logic [NLVL-1:0]   dev_vec;
  logic [NLVL-1:0]   err_vec;
  logic [CPU_W-1:0]  tgt_q;
  logic [CPU_W-1:0]  tgt_d;
  logic              tgt_ce;
  logic [NLVL-1:0]   soft_q [NCPU];

  assign src_raw = {1'b0, err_req, {GAP_W{1'b0}}, dev_req, xbus_req, bpl_req};

  irqc_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (bus_we && bus_addr == ADDR_W'(A_MSET)),
    .clr_en (bus_we && bus_addr == ADDR_W'(A_MCLR)),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  irqc_src_map u_map (
    .src_raw (src_raw),
    .mask_q  (mask_q),
    .dev_vec (dev_vec),
    .err_vec (err_vec)
  );

  // target processor select
  always_comb begin
    tgt_ce = bus_we && bus_addr == ADDR_W'(A_TGT);
    tgt_d  = bus_wdata[CPU_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_ce) tgt_q <= tgt_d;
  end

  genvar c;
  generate
    for (c = 0; c < NCPU; c++) begin : g_cpu
      logic [NLVL-1:0]  req_vec;
      logic [LVL_W-1:0] lvl_d;
      logic [LVL_W-1:0] lvl_q;

      irqc_soft_bank u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_we && bus_addr == ADDR_W'(A_CPU_BASE + c * A_CPU_STEP)),
        .clr_en (bus_we && bus_addr == ADDR_W'(A_CPU_BASE + c * A_CPU_STEP + 1)),
        .wbits  (bus_wdata[NLVL-1:0]),
        .soft_q (soft_q[c])
      );

      always_comb begin
        req_vec = soft_q[c] | err_vec;
        req_vec[TMR_LVL] = req_vec[TMR_LVL] | tmr_req[c];
        if (tgt_q == CPU_W'(c)) req_vec = req_vec | dev_vec;
      end

      irqc_prio_enc u_enc (
        .vec  (req_vec),
        .code (lvl_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
      end

      assign cpu_level[c*LVL_W +: LVL_W] = lvl_q;

      AST_ERR_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[MALL_BIT] && |(err_req & ~mask_q[ERR_HI:ERR_LO]))
          |=> lvl_q == LVL_W'(ERR_LVL)); // R10
      AST_MASKALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[MALL_BIT] && soft_q[c] == '0 && !tmr_req[c])
          |=> lvl_q == '0); // R6
      AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_req[c] |=> lvl_q >= LVL_W'(TMR_LVL)); // R8
      AST_TARGET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q != CPU_W'(c) && soft_q[c] == '0 && !tmr_req[c] && err_vec == '0)
          |=> lvl_q == '0); // R9
    end
  endgenerate

  // register read port
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_PEND): bus_rdata = src_raw;
      ADDR_W'(A_MSET),
      ADDR_W'(A_MCLR): bus_rdata = mask_q;
      ADDR_W'(A_TGT):  bus_rdata = WORD_W'(tgt_q);
      default: begin
        for (int i = 0; i < NCPU; i++)
          if (bus_addr == ADDR_W'(A_CPU_BASE + i * A_CPU_STEP))
            bus_rdata = WORD_W'(soft_q[i]);
      end
    endcase
  end

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  err_req;
  logic [8:0]  dev_req;
  logic [6:0]  xbus_req;
  logic [6:0]  bpl_req;
  logic [3:0]  tmr_req;
  logic [15:0] cpu_level;

  always #2 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_req(err_req),
    .dev_req(dev_req), .xbus_req(xbus_req), .bpl_req(bpl_req),
    .tmr_req(tmr_req), .cpu_level(cpu_level)
  );

  typedef struct {
    int          kind;   // 0 level of cpu idx, 1 read data
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 0;

  // bench model
  logic [31:0] m_mask;
  logic [1:0]  m_tgt;
  logic [15:0] m_soft [NCPU];

  function automatic int lvl_of(int b);
    int bus_tab[7] = '{2, 3, 5, 7, 9, 11, 13};
    if (b >= 27 && b <= 30) return 15;
    if (b >= 7 && b <= 13)  return bus_tab[b - 7];
    if (b <= 6)             return bus_tab[b];
    case (b)
      22: return 11; 21: return 9; 20: return 8; 19: return 10;
      18: return 4;  17: return 13; 16: return 6;
      15, 14: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic int model_lvl(int c);
    logic [31:0] raw;
    int best = 0;
    raw = {1'b0, err_req, 4'b0, dev_req, xbus_req, bpl_req};
    for (int b = 0; b < 31; b++)
      if (raw[b] && !m_mask[b] && !m_mask[31] && (b >= 27 || m_tgt == c[1:0]))
        if (lvl_of(b) > best) best = lvl_of(b);
    for (int l = 1; l < 16; l++)
      if (m_soft[c][l] && l > best) best = l;
    if (tmr_req[c] && best < 14) best = 14;
    return best;
  endfunction

  task automatic push(int kind, int idx, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic chk_levels(string req);
    for (int c = 0; c < NCPU; c++) push(0, c, 32'(model_lvl(c)), req);
  endtask

  task automatic chk_read(logic [5:0] a, logic [31:0] exp, string req);
    bus_addr = a;
    push(1, 0, exp, req);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    if (a == 6'd1) m_mask = m_mask | d;
    if (a == 6'd2) m_mask = m_mask & ~d;
    if (a == 6'd3) m_tgt = d[1:0];
    for (int c = 0; c < NCPU; c++) begin
      if (a == 6'(16 + 4 * c)) m_soft[c] = m_soft[c] | (d[15:0] & 16'hFFFE);
      if (a == 6'(17 + 4 * c)) m_soft[c] = m_soft[c] & ~(d[15:0] & 16'hFFFE);
    end
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = (it.kind == 0) ? 32'(cpu_level[it.idx*4 +: 4]) : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: kind %0d idx %0d actual %h expected %h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    err_req = '0; dev_req = '0; xbus_req = '0; bpl_req = '0; tmr_req = '0;
    m_mask = '1; m_tgt = '0;
    for (int c = 0; c < NCPU; c++) m_soft[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_levels("R1");
    chk_read(6'd1, 32'hFFFF_FFFF, "R1");
    chk_read(6'd3, 32'h0, "R1");
    for (int c = 0; c < NCPU; c++) chk_read(6'(16 + 4 * c), 32'h0, "R1");

    // R3 raw pending while masked; R5 nothing qualifies
    dev_req = 9'b0_0001_0000;   // bit 18 SCSI
    settle();
    chk_levels("R5");
    chk_read(6'd0, 32'h0004_0000, "R3");

    // R6 unmask SCSI but mask-all stays
    wr(6'd2, 32'h0004_0000);
    chk_levels("R6");
    chk_read(6'd2, 32'hFFFB_FFFF, "R2");
    wr(6'd2, 32'h8000_0000);
    chk_levels("R4");
    push(0, 0, 32'd4, "R4");
    push(0, 1, 32'd0, "R9");

    // R2 zero data has no effect
    wr(6'd1, 32'h0);
    chk_read(6'd1, 32'h7FFB_FFFF, "R2");
    wr(6'd2, 32'h0);
    chk_read(6'd1, 32'h7FFB_FFFF, "R2");

    // R5 higher shared level wins: expansion level 5 (bit 11 -> 9)
    xbus_req = 7'b001_0000;
    wr(6'd2, 32'h0000_0800);
    chk_levels("R5");
    push(0, 0, 32'd9, "R4");
    chk_read(6'd0, 32'h0004_0800, "R3");

    // R9 steer to processor 2
    wr(6'd3, 32'h2);
    chk_levels("R9");
    chk_read(6'd3, 32'h2, "R9");

    // R8 processor timer on cpu1, then mask-all
    tmr_req = 4'b0010;
    settle();
    chk_levels("R8");
    push(0, 1, 32'd14, "R8");
    wr(6'd1, 32'h8000_0000);
    chk_levels("R6");
    push(0, 2, 32'd0, "R6");
    wr(6'd2, 32'h8000_0000);
    tmr_req = 4'b0000;
    settle();

    // R10 error broadcast, independent of target
    err_req = 4'b0010;   // bit 28
    settle();
    chk_levels("R10");
    wr(6'd2, 32'h1000_0000);
    chk_levels("R10");
    for (int c = 0; c < NCPU; c++) push(0, c, 32'd15, "R10");
    chk_read(6'd0, 32'h1004_0800, "R3");
    wr(6'd1, 32'h8000_0000);
    chk_levels("R6");
    wr(6'd2, 32'h8000_0000);
    err_req = 4'b0000;
    settle();

    // R7 software interrupts coinciding with device level 9 on cpu2
    wr(6'd24, 32'hFFFF_2001);   // set bit 13 on cpu2; bit 0 and upper ignored
    chk_read(6'd24, 32'h0000_2000, "R7");
    chk_levels("R7");
    push(0, 2, 32'd13, "R7");
    chk_read(6'd16, 32'h0, "R7");
    wr(6'd25, 32'h0000_2000);
    wr(6'd24, 32'h0000_0008);   // level 3 below device
    chk_levels("R7");
    push(0, 2, 32'd9, "R7");
    wr(6'd24, 32'h0000_0200);   // same level 9
    chk_levels("R7");
    wr(6'd28, 32'h0000_0040);   // cpu3 level 6
    chk_levels("R7");
    push(0, 3, 32'd6, "R7");
    wr(6'd29, 32'h0000_0001);   // clear bit 0 only: nothing
    chk_read(6'd28, 32'h0000_0040, "R7");
    wr(6'd29, 32'h0000_0040);
    chk_read(6'd28, 32'h0, "R7");
    chk_levels("R7");

    // R4 backplane line 7 (bit 6) and keyboard (bit 14)
    wr(6'd3, 32'h0);
    bpl_req = 7'b100_0000;
    dev_req = 9'b0_0000_0001;
    wr(6'd2, 32'h0000_4040);
    chk_levels("R4");
    push(0, 0, 32'd13, "R4");
    bpl_req = '0;
    settle();
    chk_levels("R4");
    push(0, 0, 32'd12, "R4");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule